// File: doc/BRIEF.md
# External Memory Bus Cycle Controller

This block sequences the external memory bus on behalf of a processor core. The core hands it one access at a time: a read, a write, or a read-modify-write, each with an address, a two-bit memory-space code and write data. The controller turns the access into a bus cycle made of phases, one phase per clock: T0, T1, T2, then any number of wait pairs (Tw followed by T2 again), then T3. On the bus side it drives the address, the program/data/Y-space selects, the read and write strobes, a bus strobe, the write data and its output enable. It samples read data and an external wait input.

Wait states come from two places. A programmed wait count adds that many Tw/T2 pairs. An external wait handshake, when enabled, always adds at least two pairs and keeps adding pairs for as long as the wait input is found high in T2. The cycle gets whichever of the two is longer. A read-modify-write runs a read half and then a write half. The address does not change between them, but the bus strobe drops in the read half's T3 and rises again at the write half's T0. Each half has its own wait count.

States: IDLE (parked, ready for a request), T0, T1, T2, TW and T3. Transitions:
- IDLE to T0 when a request is accepted.
- T0 to T1, and T1 to T2, unconditionally.
- T2 to TW when another wait is needed; otherwise T2 to T3.
- TW back to T2.
- T3 to T0 at the end of the read half of a read-modify-write.
- T3 to IDLE at the end of every other cycle.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is held, `req_ready` is 1 and `bus_strobe`, `bus_rd`, `bus_wr`, `bus_oe` and `done` are all 0.
- R2: With no wait states, a cycle runs T0, T1, T2, T3, one clock each. `bus_strobe` is high for 3 clocks (T0 to T2). The strobe for the access is high for 2 clocks (T2 and T3): `bus_rd` for a read, `bus_wr` for a write. `done` is high in the 5th clock after the acceptance edge. `bus_rd` and `bus_wr` are never high together.
- R3: `bus_addr` and the space selects take the request's values at T0 and hold them while any bus strobe is active. Space codes: 0 gives `bus_prog_sel`. Codes 1 to 3 give `bus_data_sel`. Code bit 1 set gives `bus_y_sel`.
- R4: Read data is taken from `bus_din` at the clock edge that ends T3. It is returned on `rd_data` together with a `done` pulse that lasts exactly one clock. A write leaves `rd_data` unchanged.
- R5: A programmed count `cfg_wait` = W inserts W Tw/T2 pairs. `bus_strobe` is then high for 3+2W clocks and the access strobe for 2+2W clocks.
- R6: With `cfg_ext_wait_en` = 1, each cycle (each half of a read-modify-write) gets at least 2 wait pairs, even if `bus_wait` is never high.
- R7: With the handshake enabled, `bus_wait` is sampled at the end of each T2. If it is high there, another Tw follows. The number of waits is the larger of the programmed count and the handshake count. With the handshake disabled, `bus_wait` has no effect.
- R8: A read-modify-write (op code 2) runs a read half and then a write half. The address does not change between the halves. `bus_strobe` falls in the read half's T3 and rises at the write half's T0, giving 2 strobe pulses. There is a single `done`, carrying the read data. Total length is 9 clocks with no waits.
- R9: In a read-modify-write, the wait count restarts for the write half. The handshake minimum and the `bus_wait` sampling apply to each half separately.
- R10: `bus_oe` is high exactly while `bus_wr` is high, and is low from the next T0 on.
- R11: `req_ready` is 1 only in IDLE. A request is taken only when `req_valid` is high in IDLE; `req_valid` at any other time is ignored. Op codes: 0 read, 1 write, 2 read-modify-write, 3 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_op | input | 2 | Access type: 0 read, 1 write, 2 read-modify-write, 3 read |
| req_addr | input | AW | Access address |
| req_space | input | 2 | Space code: 0 program, 1 X data, 2 or 3 Y data |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle, request will be taken |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DW | Read data captured at the end of T3 |
| cfg_wait | input | WCW | Programmed wait-pair count |
| cfg_ext_wait_en | input | 1 | Enables the external wait handshake |
| bus_addr | output | AW | Bus address |
| bus_prog_sel | output | 1 | Program-space select |
| bus_data_sel | output | 1 | Data-space select |
| bus_y_sel | output | 1 | Y data space select |
| bus_strobe | output | 1 | Bus strobe, T0 through the last T2 |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_oe | output | 1 | Write data output enable |
| bus_dout | output | DW | Write data to the bus |
| bus_din | input | DW | Read data from the bus |
| bus_wait | input | 1 | External wait request |

## Verification
The bench drives `bus_din` with a value that changes every clock, so a read that samples in the wrong phase returns a wrong word. It runs plain reads and writes with no waits, and with programmed waits alone. It runs the handshake with the wait input held low, held high over several T2 samples, and combined with a larger programmed count. These cases separate the two-pair minimum, the extension by the wait input and the rule that the larger count wins. A wait window that is active while the handshake is disabled shows that the input is then ignored. Read-modify-write runs with waits covering only the first half, and with programmed waits on both halves. They show that the address is held, that the strobe re-pulses, and that each half counts its own waits. Requests raised while the controller is busy must produce no extra completion.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T0   = 3'd1,
        PH_T1   = 3'd2,
        PH_T2   = 3'd3,
        PH_TW   = 3'd4,
        PH_T3   = 3'd5
    } phase_e;

    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_RMW   = 2'd2;

    localparam logic [1:0] SP_PROG  = 2'd0;

    typedef struct packed {
        logic strobe;
        logic rd;
        logic wr;
        logic active;
    } bus_ctl_t;

endpackage

// File: rtl/ebc_wait_ctrl.sv
module ebc_wait_ctrl #(
    parameter int WCW          = 4,
    parameter int EXT_MIN_WAIT = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           bump,
    input  logic [WCW-1:0] cfg_wait,
    input  logic           ext_en,
    input  logic           ext_wait,
    output logic           need_wait
);

    localparam logic [WCW-1:0] EXT_FLOOR = WCW'(EXT_MIN_WAIT);
    localparam logic [WCW-1:0] CNT_MAX   = {WCW{1'b1}};

    logic [WCW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bump && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    logic prog_more;
    logic ext_more;

    always_comb begin
        prog_more = (cnt_q < cfg_wait);
        ext_more  = ext_en && ((cnt_q < EXT_FLOOR) || ext_wait);
        need_wait = prog_more || ext_more;
    end

endmodule

// File: rtl/ebc_strobe_dec.sv
module ebc_strobe_dec
    import ebc_pkg::*;
(
    input  phase_e   phase,
    input  logic     write_half,
    output bus_ctl_t ctl
);

    always_comb begin
        ctl = '0;
        unique case (phase)
            PH_IDLE: begin
                ctl = '0;
            end
            PH_T0, PH_T1: begin
                ctl.strobe = 1'b1;
                ctl.active = 1'b1;
            end
            PH_T2, PH_TW: begin
                ctl.strobe = 1'b1;
                ctl.active = 1'b1;
                ctl.rd     = !write_half;
                ctl.wr     = write_half;
            end
            PH_T3: begin
                ctl.active = 1'b1;
                ctl.rd     = !write_half;
                ctl.wr     = write_half;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebc_pkg::*;
#(
    parameter int AW           = 16,
    parameter int DW           = 24,
    parameter int WCW          = 4,
    parameter int EXT_MIN_WAIT = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     req_op,
    input  logic [AW-1:0]  req_addr,
    input  logic [1:0]     req_space,
    input  logic [DW-1:0]  req_wdata,
    output logic           req_ready,
    output logic           done,
    output logic [DW-1:0]  rd_data,
    input  logic [WCW-1:0] cfg_wait,
    input  logic           cfg_ext_wait_en,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_prog_sel,
    output logic           bus_data_sel,
    output logic           bus_y_sel,
    output logic           bus_strobe,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic           bus_oe,
    output logic [DW-1:0]  bus_dout,
    input  logic [DW-1:0]  bus_din,
    input  logic           bus_wait
);

    phase_e         state_q, state_d;
    logic           wr_half_q, wr_half_d;
    logic [AW-1:0]  addr_q;
    logic [1:0]     space_q;
    logic [1:0]     op_q;
    logic [DW-1:0]  wdata_q;
    logic [DW-1:0]  rdata_q;
    logic           done_q;
    logic           oe_q;
    logic           need_wait;
    logic           wait_clear;
    logic           wait_bump;
    logic           accept;
    logic           rmw_turn;
    logic           oe_next;
    bus_ctl_t       ctl;

    assign accept     = (state_q == PH_IDLE) && req_valid;
    assign rmw_turn   = (state_q == PH_T3) && (op_q == OP_RMW) && !wr_half_q;
    assign wait_clear = (state_q == PH_T0);
    assign wait_bump  = (state_q == PH_T2) && need_wait;

    ebc_wait_ctrl #(
        .WCW          (WCW),
        .EXT_MIN_WAIT (EXT_MIN_WAIT)
    ) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (wait_clear),
        .bump      (wait_bump),
        .cfg_wait  (cfg_wait),
        .ext_en    (cfg_ext_wait_en),
        .ext_wait  (bus_wait),
        .need_wait (need_wait)
    );

    ebc_strobe_dec u_dec (
        .phase      (state_q),
        .write_half (wr_half_q),
        .ctl        (ctl)
    );

    // Next phase and half selection
    always_comb begin
        state_d   = state_q;
        wr_half_d = wr_half_q;
        unique case (state_q)
            PH_IDLE: begin
                if (req_valid) begin
                    state_d   = PH_T0;
                    wr_half_d = (req_op == OP_WRITE);
                end
            end
            PH_T0:   state_d = PH_T1;
            PH_T1:   state_d = PH_T2;
            PH_T2:   state_d = need_wait ? PH_TW : PH_T3;
            PH_TW:   state_d = PH_T2;
            PH_T3: begin
                if (rmw_turn) begin
                    state_d   = PH_T0;
                    wr_half_d = 1'b1;
                end else begin
                    state_d   = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= PH_IDLE;
            wr_half_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            wr_half_q <= wr_half_d;
        end
    end

    assign oe_next = wr_half_d &&
                     ((state_d == PH_T2) || (state_d == PH_TW) || (state_d == PH_T3));

    // Request capture, read capture, completion and output enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            space_q <= '0;
            op_q    <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                space_q <= req_space;
                op_q    <= req_op;
                wdata_q <= req_wdata;
            end
            if ((state_q == PH_T3) && !wr_half_q) begin
                rdata_q <= bus_din;
            end
            done_q <= (state_q == PH_T3) && !rmw_turn;
            oe_q   <= oe_next;
        end
    end

    // Outputs
    always_comb begin
        req_ready    = (state_q == PH_IDLE);
        done         = done_q;
        rd_data      = rdata_q;
        bus_addr     = addr_q;
        bus_dout     = wdata_q;
        bus_strobe   = ctl.strobe;
        bus_rd       = ctl.rd;
        bus_wr       = ctl.wr;
        bus_oe       = oe_q;
        bus_prog_sel = ctl.active && (space_q == SP_PROG);
        bus_data_sel = ctl.active && (space_q != SP_PROG);
        bus_y_sel    = ctl.active && space_q[1];
    end

endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
    parameter int AW           = 16,
    parameter int WCW          = 4,
    parameter int EXT_MIN_WAIT = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_ready,
    input logic           done,
    input logic [AW-1:0]  bus_addr,
    input logic           bus_strobe,
    input logic           bus_rd,
    input logic           bus_wr,
    input logic           bus_oe,
    input logic [WCW-1:0] cfg_wait,
    input logic           cfg_ext_wait_en
);

    localparam int RW = WCW + 3;
    localparam logic [RW-1:0] EXT_LEN = RW'(3 + 2 * EXT_MIN_WAIT);

    logic [RW-1:0] run_q;
    logic [RW-1:0] min_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bus_strobe) begin
            if (run_q != {RW{1'b1}}) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    assign min_len = RW'(3) + RW'({cfg_wait, 1'b0});

    assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(bus_strobe || bus_rd || bus_wr));

    assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> $stable(bus_addr));

    assert_rmw_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_strobe) && $past(bus_rd)) |-> $stable(bus_addr));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_oe_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe == bus_wr);

    assert_prog_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_strobe) |-> (run_q >= min_len));

    assert_ext_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ext_wait_en && $fell(bus_strobe)) |-> (run_q >= EXT_LEN));

endmodule

bind ext_bus_seq ebc_checker #(
    .AW           (AW),
    .WCW          (WCW),
    .EXT_MIN_WAIT (EXT_MIN_WAIT)
) u_ebc_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_ready       (req_ready),
    .done            (done),
    .bus_addr        (bus_addr),
    .bus_strobe      (bus_strobe),
    .bus_rd          (bus_rd),
    .bus_wr          (bus_wr),
    .bus_oe          (bus_oe),
    .cfg_wait        (cfg_wait),
    .cfg_ext_wait_en (cfg_ext_wait_en)
);

// File: tb/ext_bus_seq_bench.sv
`timescale 1ns/1ps
module ext_bus_seq_bench;

    localparam int AW  = 16;
    localparam int DW  = 24;
    localparam int WCW = 4;

    logic           clk;
    logic           rst_n;
    logic           req_valid;
    logic [1:0]     req_op;
    logic [AW-1:0]  req_addr;
    logic [1:0]     req_space;
    logic [DW-1:0]  req_wdata;
    logic           req_ready;
    logic           done;
    logic [DW-1:0]  rd_data;
    logic [WCW-1:0] cfg_wait;
    logic           cfg_ext_wait_en;
    logic [AW-1:0]  bus_addr;
    logic           bus_prog_sel, bus_data_sel, bus_y_sel;
    logic           bus_strobe, bus_rd, bus_wr, bus_oe;
    logic [DW-1:0]  bus_dout;
    logic [DW-1:0]  bus_din;
    logic           bus_wait;

    ext_bus_seq u_ext_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_space(req_space), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rd_data(rd_data),
        .cfg_wait(cfg_wait), .cfg_ext_wait_en(cfg_ext_wait_en),
        .bus_addr(bus_addr), .bus_prog_sel(bus_prog_sel),
        .bus_data_sel(bus_data_sel), .bus_y_sel(bus_y_sel),
        .bus_strobe(bus_strobe), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_wait(bus_wait)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int a_ref  = 0;
    int win_lo = 0;
    int win_hi = -1;

    function automatic logic [DW-1:0] mix(int c);
        return DW'((c * 40503) ^ 24'h35A96B);
    endfunction

    always_comb bus_din  = mix(cyc);
    always_comb bus_wait = ((cyc - a_ref) >= win_lo) && ((cyc - a_ref) <= win_hi);

    typedef struct {
        int            len;
        int            bs;
        int            rdn;
        int            wrn;
        int            rises;
        logic [DW-1:0] rdata;
        string         tag;
    } exp_t;

    exp_t q[$];

    int n_chk  = 0;
    int n_fail = 0;
    bit closed = 0;

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic int waits(int s, int cfg, bit en, int lo, int hi);
        int k = 0;
        for (int g = 0; g < 20; g++) begin
            int rel = s + 2 + 2 * k;
            bit ext = (rel >= lo) && (rel <= hi);
            if ((k < cfg) || (en && ((k < 2) || ext))) k++;
            else break;
        end
        return k;
    endfunction

    logic [DW-1:0] last_rdata = '0;

    // Driver: issues one request, pushes the expected result
    task automatic issue(logic [1:0] op, logic [AW-1:0] addr, logic [1:0] sp,
                         logic [DW-1:0] wd, int cfg, bit en, int lo, int hi,
                         bit junk, string tag);
        exp_t e;
        int w1, w2;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_wait        = WCW'(cfg);
        cfg_ext_wait_en = en;
        a_ref  = cyc;
        win_lo = lo;
        win_hi = hi;
        req_op    = op;
        req_addr  = addr;
        req_space = sp;
        req_wdata = wd;
        req_valid = 1'b1;
        w1 = waits(1, cfg, en, lo, hi);
        e.tag = tag;
        if (op == 2'd2) begin
            w2 = waits(5 + 2 * w1, cfg, en, lo, hi);
            e.len = 9 + 2 * w1 + 2 * w2;
            e.bs  = 6 + 2 * w1 + 2 * w2;
            e.rdn = 2 + 2 * w1;
            e.wrn = 2 + 2 * w2;
            e.rises = 2;
            e.rdata = mix(a_ref + 4 + 2 * w1);
        end else if (op == 2'd1) begin
            e.len = 5 + 2 * w1;
            e.bs  = 3 + 2 * w1;
            e.rdn = 0;
            e.wrn = 2 + 2 * w1;
            e.rises = 1;
            e.rdata = last_rdata;
        end else begin
            e.len = 5 + 2 * w1;
            e.bs  = 3 + 2 * w1;
            e.rdn = 2 + 2 * w1;
            e.wrn = 0;
            e.rises = 1;
            e.rdata = mix(a_ref + 4 + 2 * w1);
        end
        last_rdata = e.rdata;
        q.push_back(e);
        @(negedge clk);
        if (junk) begin
            // R11: requests while busy must be ignored
            req_addr  = addr ^ 16'hFFFF;
            req_op    = 2'd0;
            @(negedge clk);
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // Monitor: accumulates one transaction and compares on done
    bit            m_active = 0;
    int            m_cnt, m_bs, m_rd, m_wr, m_oe, m_rises, m_oe_bad, m_addr_bad;
    bit            m_prev_bs;
    logic [AW-1:0] m_addr;
    logic [1:0]    m_space;

    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            if (m_active) begin
                m_cnt++;
                if (bus_strobe) m_bs++;
                if (bus_strobe && !m_prev_bs) m_rises++;
                m_prev_bs = bus_strobe;
                if (bus_rd) m_rd++;
                if (bus_wr) m_wr++;
                if (bus_oe) m_oe++;
                if (bus_oe != bus_wr) m_oe_bad++;
                if (bus_strobe || bus_rd || bus_wr) begin
                    if ((bus_addr != m_addr) || (bus_prog_sel != (m_space == 2'd0)) ||
                        (bus_data_sel != (m_space != 2'd0)) || (bus_y_sel != m_space[1]))
                        m_addr_bad++;
                end
            end
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R11", "done without request", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(m_cnt == e.len, e.tag, "cycle length", m_cnt, e.len);
                    check(m_bs == e.bs, "R2", "strobe clocks", m_bs, e.bs);
                    check(m_rd == e.rdn, "R2", "read strobe clocks", m_rd, e.rdn);
                    check(m_wr == e.wrn, "R2", "write strobe clocks", m_wr, e.wrn);
                    check(m_rises == e.rises, "R8", "strobe pulses", m_rises, e.rises);
                    check(rd_data == e.rdata, "R4", "read data", rd_data, e.rdata);
                    check(m_addr_bad == 0, "R3", "address/space mismatches", m_addr_bad, 0);
                    check((m_oe == e.wrn) && (m_oe_bad == 0), "R10", "oe clocks",
                          m_oe, e.wrn);
                end
                m_active = 0;
            end
            if (req_valid && req_ready) begin
                m_active   = 1;
                m_cnt      = 0;
                m_bs       = 0;
                m_rd       = 0;
                m_wr       = 0;
                m_oe       = 0;
                m_rises    = 0;
                m_oe_bad   = 0;
                m_addr_bad = 0;
                m_prev_bs  = 0;
                m_addr     = req_addr;
                m_space    = req_space;
            end
        end
    end

    task automatic close_out();
        if (!closed) begin
            closed = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        close_out();
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_op = '0;
        req_addr = '0;
        req_space = '0;
        req_wdata = '0;
        cfg_wait = '0;
        cfg_ext_wait_en = 1'b0;
        repeat (3) @(negedge clk);
        #3;
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check(bus_strobe == 1'b0, "R1", "strobe in reset", bus_strobe, 0);
        check((bus_rd | bus_wr) == 1'b0, "R1", "rd/wr in reset", bus_rd | bus_wr, 0);
        check(bus_oe == 1'b0, "R1", "oe in reset", bus_oe, 0);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        @(negedge clk);
        rst_n = 1'b1;

        issue(2'd0, 16'h1234, 2'd0, 24'h000000, 0, 0, 0, -1, 0, "R2");
        issue(2'd1, 16'h00A5, 2'd1, 24'hABCDEF, 0, 0, 0, -1, 0, "R10");
        issue(2'd0, 16'hBEEF, 2'd2, 24'h000000, 3, 0, 0, -1, 0, "R5");
        issue(2'd0, 16'h4321, 2'd3, 24'h000000, 0, 1, 0, -1, 0, "R6");
        issue(2'd0, 16'h0F0F, 2'd1, 24'h000000, 0, 1, 1, 12, 0, "R7");
        issue(2'd0, 16'h7777, 2'd0, 24'h000000, 4, 1, 0, -1, 0, "R7");
        issue(2'd0, 16'h5A5A, 2'd2, 24'h000000, 0, 0, 1, 50, 0, "R7");
        issue(2'd2, 16'hC0DE, 2'd1, 24'h123456, 0, 0, 0, -1, 0, "R8");
        issue(2'd2, 16'hD00D, 2'd2, 24'h654321, 0, 1, 1, 8, 0, "R9");
        issue(2'd1, 16'h3C3C, 2'd0, 24'h0A0B0C, 1, 0, 0, -1, 1, "R11");
        issue(2'd2, 16'hFACE, 2'd3, 24'hFEDCBA, 2, 0, 0, -1, 0, "R9");
        issue(2'd1, 16'h0001, 2'd2, 24'h111111, 2, 1, 0, -1, 0, "R6");

        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R11", "pending results", q.size(), 0);
        close_out();
    end

endmodule